// File: doc/BRIEF.md
# Rotational Per-Register Rename Unit

This unit turns operand references of a pre-renamed instruction schedule into physical register numbers while that schedule is replayed on an in-order pipeline. There is no free list and no mapping table. Each architectural register owns a small ring of physical slots. Each operand names its architectural register and a version suffix. Suffix 0 is the value that was live when the trace began. Every write in the trace takes the next version.

Each register holds two pointer fields, and a select bit decides which field is the base and which is the local last-written pointer. When a trace issues, the select bit flips, so the pointer that was last written becomes the base of the following trace. A committed pointer per register keeps the base that the last committed trace left behind. An abort returns every register to that pointer. A write that would need more versions than the ring can hold is reported as an illegal schedule and aborts the trace. When the replay mode is off, the pointer state is frozen.

Top module: `rot_rename`

## Requirements
- R1: One cycle after `rd_valid`, `rd_pvalid` is high and `rd_preg` equals `rd_areg*POOL + ((base + rd_suffix) mod POOL)`, where base is the register's current base pointer.
- R2: One cycle after an accepted write, `wr_pvalid` is high and `wr_preg` equals `wr_areg*POOL + ((local + 1) mod POOL)`. The local pointer of that register then advances by one and wraps modulo POOL.
- R3: An accepted trace issue makes each register's last-written pointer its new base, so that a read with suffix 0 returns the slot last written.
- R4: At most two traces are active at once. An issue that arrives while an issued trace is still uncommitted is ignored, unless a commit is accepted in the same cycle.
- R5: An accepted commit stores, for each register, the base that the committed trace handed on in the committed pointer. A commit with no issued trace outstanding is ignored.
- R6: An abort flips back the select bits if an issued trace is outstanding, sets the base and local pointers of every register to its committed pointer, and clears the outstanding trace.
- R7: A write to a register that already has POOL-1 new versions in the current trace pulses `sched_err` one cycle later, gives no `wr_pvalid`, and acts as an abort.
- R8: While `replay_mode` is low, writes, issues, commits and aborts leave the pointer state unchanged and produce neither `wr_pvalid` nor `sched_err`. Reads still map.
- R9: Reset clears all select bits and all pointers to 0 and drives every output valid low.
- R10: When events occur in the same cycle, the write is applied first, then the commit, then the issue. An abort overrides all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| replay_mode | input | 1 | High while a reordered schedule is replayed |
| rd_valid | input | 1 | Read operand present |
| rd_areg | input | log2(NUM_AREGS) | Architectural register of the read |
| rd_suffix | input | log2(POOL) | Version suffix of the read |
| wr_valid | input | 1 | Destination write present |
| wr_areg | input | log2(NUM_AREGS) | Architectural register written |
| issue_pulse | input | 1 | Current trace has issued |
| commit_pulse | input | 1 | Oldest issued trace commits |
| abort_pulse | input | 1 | Misspeculation or interrupt |
| rd_pvalid | output | 1 | Registered read result valid |
| rd_preg | output | log2(NUM_AREGS)+log2(POOL) | Physical register for the read |
| wr_pvalid | output | 1 | Registered write result valid |
| wr_preg | output | log2(NUM_AREGS)+log2(POOL) | Physical register for the write |
| sched_err | output | 1 | Illegal-schedule pulse |

## Verification
The bench builds the unit with four architectural registers and a ring of four slots. Four registers keep every expected physical number easy to work out. A ring of four lets a few writes wrap the local pointer past slot 3, and a fourth write inside one trace reaches the version limit. With these values a short run also covers a full issue, commit and abort cycle while one trace is outstanding, and the same-cycle event orderings.

// File: rtl/rr_pkg.sv
package rr_pkg;
  // Trace events after qualification, broadcast to every register entry.
  typedef struct packed {
    logic abort;      // restore committed pointers
    logic commit;     // capture pending base into committed pointer
    logic issue;      // flip select bit, start next trace
    logic flip_back;  // an issued trace is outstanding at abort time
  } rr_evt_t;
endpackage

// File: rtl/rr_ctrl.sv
module rr_ctrl
  import rr_pkg::*;
#(
  parameter int NUM_AREGS = 16,
  localparam int AW = $clog2(NUM_AREGS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 replay_mode,
  input  logic                 wr_valid,
  input  logic [AW-1:0]        wr_areg,
  input  logic [NUM_AREGS-1:0] full_vec,
  input  logic                 issue_pulse,
  input  logic                 commit_pulse,
  input  logic                 abort_pulse,
  output rr_evt_t              evt,
  output logic                 wr_ok,
  output logic                 illegal,
  output logic                 outstanding
);
  always_comb begin
    illegal        = replay_mode & wr_valid & full_vec[wr_areg];
    wr_ok          = replay_mode & wr_valid & ~full_vec[wr_areg];
    evt.abort      = replay_mode & (abort_pulse | illegal);
    evt.commit     = replay_mode & ~evt.abort & commit_pulse & outstanding;
    evt.issue      = replay_mode & ~evt.abort & issue_pulse &
                     (~outstanding | evt.commit);
    evt.flip_back  = outstanding;
  end

  always_ff @(posedge clk) begin
    if (rst)             outstanding <= 1'b0;
    else if (evt.abort)  outstanding <= 1'b0;
    else if (evt.issue)  outstanding <= 1'b1;
    else if (evt.commit) outstanding <= 1'b0;
  end
endmodule

// File: rtl/rr_entry.sv
module rr_entry
  import rr_pkg::*;
#(
  parameter int POOL = 4,
  localparam int PW = $clog2(POOL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_hit,
  input  rr_evt_t       evt,
  output logic [PW-1:0] base_o,
  output logic [PW-1:0] local_o,
  output logic          full_o
);
  logic [PW-1:0] fld0, fld1, cptr, pend, vcnt, local_n;
  logic          sel;

  // sel chooses which field is the base; the other is the local pointer.
  always_comb begin
    base_o  = sel ? fld1 : fld0;
    local_o = sel ? fld0 : fld1;
    local_n = local_o + PW'(wr_hit);   // POOL is a power of two: wraps
    full_o  = (vcnt == PW'(POOL - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fld0 <= '0; fld1 <= '0; cptr <= '0; pend <= '0; vcnt <= '0;
      sel  <= 1'b0;
    end else if (evt.abort) begin
      if (evt.flip_back) sel <= ~sel;
      fld0 <= cptr;
      fld1 <= cptr;
      vcnt <= '0;
    end else begin
      if (evt.commit) cptr <= pend;
      if (evt.issue) begin
        sel  <= ~sel;
        fld0 <= local_n;
        fld1 <= local_n;
        pend <= local_n;
        vcnt <= '0;
      end else if (wr_hit) begin
        if (sel) fld0 <= local_n;
        else     fld1 <= local_n;
        vcnt <= vcnt + PW'(1);
      end
    end
  end
endmodule

// File: rtl/rot_rename.sv
module rot_rename
  import rr_pkg::*;
#(
  parameter int NUM_AREGS = 16,
  parameter int POOL      = 4,
  localparam int AW  = $clog2(NUM_AREGS),
  localparam int PW  = $clog2(POOL),
  localparam int PRW = AW + PW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           replay_mode,
  input  logic           rd_valid,
  input  logic [AW-1:0]  rd_areg,
  input  logic [PW-1:0]  rd_suffix,
  input  logic           wr_valid,
  input  logic [AW-1:0]  wr_areg,
  input  logic           issue_pulse,
  input  logic           commit_pulse,
  input  logic           abort_pulse,
  output logic           rd_pvalid,
  output logic [PRW-1:0] rd_preg,
  output logic           wr_pvalid,
  output logic [PRW-1:0] wr_preg,
  output logic           sched_err
);
  rr_evt_t              evt;
  logic                 wr_ok, illegal, outstanding;
  logic [NUM_AREGS-1:0] full_vec;
  logic [PW-1:0]        base_arr  [NUM_AREGS];
  logic [PW-1:0]        local_arr [NUM_AREGS];
  logic [PW-1:0]        rd_slot, wr_slot;

  rr_ctrl #(.NUM_AREGS(NUM_AREGS)) u_ctrl (
    .clk(clk), .rst(rst), .replay_mode(replay_mode),
    .wr_valid(wr_valid), .wr_areg(wr_areg), .full_vec(full_vec),
    .issue_pulse(issue_pulse), .commit_pulse(commit_pulse),
    .abort_pulse(abort_pulse), .evt(evt), .wr_ok(wr_ok),
    .illegal(illegal), .outstanding(outstanding)
  );

  for (genvar g = 0; g < NUM_AREGS; g++) begin : g_ent
    rr_entry #(.POOL(POOL)) u_ent (
      .clk(clk), .rst(rst),
      .wr_hit(wr_ok && (wr_areg == AW'(g))),
      .evt(evt),
      .base_o(base_arr[g]), .local_o(local_arr[g]), .full_o(full_vec[g])
    );
  end

  always_comb begin
    rd_slot = base_arr[rd_areg] + rd_suffix;
    wr_slot = local_arr[wr_areg] + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pvalid <= 1'b0; wr_pvalid <= 1'b0; sched_err <= 1'b0;
      rd_preg   <= '0;   wr_preg   <= '0;
    end else begin
      rd_pvalid <= rd_valid;
      rd_preg   <= {rd_areg, rd_slot};
      wr_pvalid <= wr_ok;
      wr_preg   <= {wr_areg, wr_slot};
      sched_err <= illegal;
    end
  end
endmodule

// File: rtl/rot_rename_chk.sv
module rot_rename_chk #(
  parameter int NUM_AREGS = 16,
  parameter int POOL      = 4,
  localparam int AW  = $clog2(NUM_AREGS),
  localparam int PW  = $clog2(POOL),
  localparam int PRW = AW + PW
) (
  input logic           clk,
  input logic           rst,
  input logic           replay_mode,
  input logic           rd_valid,
  input logic [AW-1:0]  rd_areg,
  input logic           wr_valid,
  input logic           issue_pulse,
  input logic           abort_pulse,
  input logic           rd_pvalid,
  input logic [PRW-1:0] rd_preg,
  input logic           wr_pvalid,
  input logic           sched_err,
  input logic           outstanding
);
  initial begin
    a_r1_pool_pow2: assert ((POOL & (POOL - 1)) == 0 && POOL >= 2);
  end

  a_r1_rd_valid: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> rd_pvalid);
  a_r1_rd_idle: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |=> !rd_pvalid);
  a_r1_rd_areg: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> rd_preg[PRW-1 -: AW] == $past(rd_areg));
  a_r7_err_no_write: assert property (@(posedge clk) disable iff (rst)
    sched_err |-> !wr_pvalid);
  a_r7_err_cause: assert property (@(posedge clk) disable iff (rst)
    !(wr_valid && replay_mode) |=> !sched_err);
  a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
    !replay_mode |=> !wr_pvalid && !sched_err && $stable(outstanding));
  a_r4_issue_sets: assert property (@(posedge clk) disable iff (rst)
    !outstanding && !issue_pulse |=> !outstanding);
  a_r6_abort_clears: assert property (@(posedge clk) disable iff (rst)
    abort_pulse && replay_mode |=> !outstanding);
endmodule

bind rot_rename rot_rename_chk #(.NUM_AREGS(NUM_AREGS), .POOL(POOL)) u_chk (
  .clk(clk), .rst(rst), .replay_mode(replay_mode), .rd_valid(rd_valid),
  .rd_areg(rd_areg), .wr_valid(wr_valid), .issue_pulse(issue_pulse),
  .abort_pulse(abort_pulse), .rd_pvalid(rd_pvalid), .rd_preg(rd_preg),
  .wr_pvalid(wr_pvalid), .sched_err(sched_err), .outstanding(outstanding)
);

// File: tb/rot_rename_test.sv
module rot_rename_test;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 4;
  localparam int PL = 4;
  localparam logic [2:0] OP_RD = 3'd0, OP_WR = 3'd1, OP_IS = 3'd2,
                         OP_CM = 3'd3, OP_AB = 3'd4;
  localparam int NV = 24;
  // {op, areg, suffix, expected preg, expected error}
  localparam logic [11:0] VEC [NV] = '{
    {OP_RD, 2'd1, 2'd0, 4'd4,  1'b0},  // 0  R1 base 0 after reset
    {OP_WR, 2'd1, 2'd0, 4'd5,  1'b0},  // 1  R2
    {OP_WR, 2'd1, 2'd0, 4'd6,  1'b0},  // 2  R2
    {OP_RD, 2'd1, 2'd2, 4'd6,  1'b0},  // 3  R1
    {OP_IS, 2'd0, 2'd0, 4'd0,  1'b0},  // 4  R3 issue trace A
    {OP_RD, 2'd1, 2'd0, 4'd6,  1'b0},  // 5  R3 base = last written
    {OP_WR, 2'd1, 2'd0, 4'd7,  1'b0},  // 6  R2
    {OP_WR, 2'd1, 2'd0, 4'd4,  1'b0},  // 7  R2 wrap to slot 0
    {OP_RD, 2'd1, 2'd3, 4'd5,  1'b0},  // 8  R1 (2+3) mod 4
    {OP_IS, 2'd0, 2'd0, 4'd0,  1'b0},  // 9  R4 ignored, A outstanding
    {OP_RD, 2'd1, 2'd0, 4'd6,  1'b0},  // 10 R4 base unchanged
    {OP_CM, 2'd0, 2'd0, 4'd0,  1'b0},  // 11 R5 committed = 2
    {OP_IS, 2'd0, 2'd0, 4'd0,  1'b0},  // 12 R4 now accepted
    {OP_RD, 2'd1, 2'd0, 4'd4,  1'b0},  // 13 R3
    {OP_WR, 2'd2, 2'd0, 4'd9,  1'b0},  // 14 R2
    {OP_AB, 2'd0, 2'd0, 4'd0,  1'b0},  // 15 R6
    {OP_RD, 2'd1, 2'd0, 4'd6,  1'b0},  // 16 R6 R5 base = committed 2
    {OP_RD, 2'd2, 2'd1, 4'd9,  1'b0},  // 17 R6
    {OP_WR, 2'd3, 2'd0, 4'd13, 1'b0},  // 18 R2
    {OP_WR, 2'd3, 2'd0, 4'd14, 1'b0},  // 19 R2
    {OP_WR, 2'd3, 2'd0, 4'd15, 1'b0},  // 20 R2
    {OP_WR, 2'd3, 2'd0, 4'd0,  1'b1},  // 21 R7 fourth version
    {OP_RD, 2'd3, 2'd0, 4'd12, 1'b0},  // 22 R7 acted as abort
    {OP_RD, 2'd1, 2'd1, 4'd7,  1'b0}   // 23 R7 others restored
  };

  logic       clk = 1'b0, rst = 1'b1, replay_mode = 1'b0;
  logic       rd_valid = 1'b0, wr_valid = 1'b0;
  logic [1:0] rd_areg = '0, rd_suffix = '0, wr_areg = '0;
  logic       issue_pulse = 1'b0, commit_pulse = 1'b0, abort_pulse = 1'b0;
  logic       rd_pvalid, wr_pvalid, sched_err;
  logic [3:0] rd_preg, wr_preg;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rot_rename #(.NUM_AREGS(NA), .POOL(PL)) uut (
    .clk(clk), .rst(rst), .replay_mode(replay_mode),
    .rd_valid(rd_valid), .rd_areg(rd_areg), .rd_suffix(rd_suffix),
    .wr_valid(wr_valid), .wr_areg(wr_areg), .issue_pulse(issue_pulse),
    .commit_pulse(commit_pulse), .abort_pulse(abort_pulse),
    .rd_pvalid(rd_pvalid), .rd_preg(rd_preg), .wr_pvalid(wr_pvalid),
    .wr_preg(wr_preg), .sched_err(sched_err)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    rd_valid = 0; wr_valid = 0; issue_pulse = 0; commit_pulse = 0;
    abort_pulse = 0;
  endtask

  // Inputs are set at a falling edge and held over one rising edge;
  // the registered outputs are sampled at the following falling edge.
  task automatic cycle();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; idle(); cycle(); cycle(); rst = 0;
  endtask

  task automatic read(logic [1:0] a, logic [1:0] s);
    rd_valid = 1; rd_areg = a; rd_suffix = s; cycle();
  endtask

  initial begin
    do_reset();
    // R9 reset state
    check("R9 rd_pvalid", rd_pvalid, 0);
    check("R9 wr_pvalid", wr_pvalid, 0);
    check("R9 sched_err", sched_err, 0);
    read(2'd2, 2'd3);
    check("R9 base zero", rd_preg, 11);

    replay_mode = 1;
    for (int i = 0; i < NV; i++) begin
      logic [11:0] v;
      v = VEC[i];
      case (v[11:9])
        OP_RD: begin rd_valid = 1; rd_areg = v[8:7]; rd_suffix = v[6:5]; end
        OP_WR: begin wr_valid = 1; wr_areg = v[8:7]; end
        OP_IS: issue_pulse = 1;
        OP_CM: commit_pulse = 1;
        default: abort_pulse = 1;
      endcase
      cycle();
      if (v[11:9] == OP_RD) begin
        check("R1 rd_pvalid", rd_pvalid, 1);
        check("R1 read map", rd_preg, int'(v[4:1]));
      end else if (v[11:9] == OP_WR && !v[0]) begin
        check("R2 wr_pvalid", wr_pvalid, 1);
        check("R2 write slot", wr_preg, int'(v[4:1]));
      end else if (v[11:9] == OP_WR) begin
        check("R7 sched_err", sched_err, 1);
        check("R7 no wr_pvalid", wr_pvalid, 0);
      end
    end

    // R8: replay off freezes pointer state
    do_reset();
    replay_mode = 0;
    wr_valid = 1; wr_areg = 0; issue_pulse = 1; cycle();
    check("R8 no wr_pvalid", wr_pvalid, 0);
    replay_mode = 1;
    read(2'd0, 2'd0);
    check("R8 base unchanged", rd_preg, 0);

    // R10: write then issue in one cycle
    wr_valid = 1; wr_areg = 0; issue_pulse = 1; cycle();
    check("R10 write slot", wr_preg, 1);
    read(2'd0, 2'd0);
    check("R10 issue after write", rd_preg, 1);

    // R10 R6: abort wins over issue, restores committed 0
    abort_pulse = 1; issue_pulse = 1; cycle();
    read(2'd0, 2'd0);
    check("R10 abort overrides", rd_preg, 0);

    // R6: abort cleared the outstanding trace, so issue is accepted
    wr_valid = 1; wr_areg = 0; issue_pulse = 1; cycle();
    read(2'd0, 2'd0);
    check("R6 outstanding cleared", rd_preg, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule